// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave port that gives a host processor access to a register file over a four-wire serial link. The wires are a chip select (active low), a serial clock, a data-in line and a data-out line, plus a static polarity pin. Each selected frame carries sixteen bits. The first eight bits are a command byte that holds the direction and the register address. The second eight bits are the data byte. On a write the data byte comes in from the host and is committed to the register file. On a read the data byte is fetched from the register file and shifted back to the host.

All pins are brought into the block's system clock domain through a synchronizer, and the serial clock edges are detected there. The serial clock must therefore stay in each level for several system clock cycles. The data-out line is modelled as a data bit plus an output enable, and the enable is low whenever the line should float. The polarity pin picks the serial clock edge at which the host may sample the data out. It must be held steady while chip select is asserted. The register file sits outside the block. It sees an address, a one-cycle write strobe with write data, and a one-cycle read strobe, and it returns read data combinationally for the address presented.

Top module: `srp_port`

## Requirements
- R1: After reset `sdo_oe`, `reg_we` and `reg_re` are all low.
- R2: Bits shift least significant bit first. In the command byte, bit 0 set means read and clear means write, and bits [4:1] carry the register address. On a write, `reg_we` pulses for exactly one cycle, with the command address and the eight data bits, only after the sixteenth rising serial clock edge.
- R3: `sdi` is taken only at rising serial clock edges. Its value at falling edges has no effect.
- R4: With `spol` low on a read, data bit Dk (k = 0..7) is driven with `sdo_oe` high before the rising edge of frame bit 9+k, so it is valid at that rising edge. The output is enabled only during read frames.
- R5: With `spol` high on a read, data bit Dk is driven with `sdo_oe` high from the rising edge of frame bit 9+k, so it is valid at the following falling edge.
- R6: `sdo_oe` stays low for the whole of a write frame.
- R7: After D7 the output floats. With `spol` low it floats from the sixteenth rising edge, and with `spol` high it floats from the falling edge that follows it.
- R8: The serial clock may idle high or low when chip select asserts, and both idle levels give the same transfers.
- R9: Deasserting chip select at any point ends the frame. The output floats, the bit count restarts, and an incomplete write changes no register.
- R10: A read frame gives exactly one `reg_re` pulse, with `reg_addr` holding the command address.
- R11: Serial clock edges after the sixteenth rising edge are ignored until chip select deasserts. There is no second write and no further output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| spol | input | 1 | Output edge select: 0 valid at rising, 1 valid at falling |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for sdo, low means high-Z |
| reg_addr | output | ADDR_W | Register address from command byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W | Write data |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data for reg_addr |

## Verification
Every pin change takes two synchronizer cycles to arrive and one more register stage to act, so `reg_we`, `reg_re`, `sdo` and `sdo_oe` respond three system clock cycles after the serial clock edge that causes them. The bench holds each serial clock level for eight system cycles and samples the output at the end of a level, just before the next edge, the same way a host would. Strobes are counted by a monitor on every cycle, and each count is compared over the whole frame once it has ended. The bench changes `sdi` in the middle of every high phase so that any sampling on the falling edge would corrupt the result.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic {
      EDGE_RISE_VALID = 1'b0,
      EDGE_FALL_VALID = 1'b1
   } out_edge_e;

   function automatic int frame_bits(int dw);
      return 2 * dw;
   endfunction

   function automatic int cnt_width(int dw);
      return $clog2(2 * dw + 1);
   endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int               STAGES  = 2,
   parameter int               W       = 1,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rise,
   input  logic              sdi,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              cmd_valid,
   output logic              cmd_rd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req
);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * DATA_W - 1);
   localparam logic [CNT_W-1:0] FULL      = CNT_W'(2 * DATA_W);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] nxt;
   logic              take;

   assign nxt  = {sdi, shreg[DATA_W-1:1]};
   assign take = rise && (bit_cnt != FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         cmd_valid <= 1'b0;
         cmd_rd    <= 1'b0;
         cmd_addr  <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
         rd_req    <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         rd_req <= 1'b0;
         if (!sel) begin
            bit_cnt   <= '0;
            cmd_valid <= 1'b0;
            cmd_rd    <= 1'b0;
         end else if (take) begin
            shreg   <= nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CMD_LAST) begin
               cmd_valid <= 1'b1;
               cmd_rd    <= nxt[0];
               cmd_addr  <= nxt[ADDR_W:1];
               rd_req    <= nxt[0];
            end
            if ((bit_cnt == DATA_LAST) && !cmd_rd) begin
               wr_en   <= 1'b1;
               wr_data <= nxt;
            end
         end
      end
   end
endmodule

// File: rtl/srp_tx.sv
module srp_tx
   import srp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rise,
   input  logic              fall,
   input  logic              spol,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic              load,
   input  logic [DATA_W-1:0] rdata,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * DATA_W - 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(2 * DATA_W);

   logic [DATA_W-1:0] obuf;
   logic              rd_act;
   logic              in_data;
   logic [IDX_W-1:0]  idx;
   out_edge_e         mode;

   assign mode    = out_edge_e'(spol);
   assign in_data = (bit_cnt >= FIRST) && (bit_cnt <= LAST);
   assign idx     = IDX_W'(bit_cnt - FIRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obuf   <= '0;
         rd_act <= 1'b0;
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (!sel) begin
         rd_act <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (load) begin
         obuf   <= rdata;
         rd_act <= 1'b1;
         if (mode == EDGE_RISE_VALID) begin
            sdo    <= rdata[0];
            sdo_oe <= 1'b1;
         end
      end else if (rd_act) begin
         unique case (mode)
            EDGE_RISE_VALID: begin
               if (fall && in_data && (bit_cnt != FIRST)) sdo <= obuf[idx];
               else if (rise && (bit_cnt == LAST))        sdo_oe <= 1'b0;
            end
            EDGE_FALL_VALID: begin
               if (rise && in_data) begin
                  sdo    <= obuf[idx];
                  sdo_oe <= 1'b1;
               end else if (fall && (bit_cnt == FULL)) begin
                  sdo_oe <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/srp_port.sv
module srp_port
   import srp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              spol,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);
   localparam int CNT_W      = cnt_width(DATA_W);
   localparam int FRAME_BITS = frame_bits(DATA_W);

   if (DATA_W < 2)          begin : g_bad_dw  $error("DATA_W must be at least 2");        end
   if (ADDR_W + 1 > DATA_W) begin : g_bad_aw  $error("command byte cannot hold ADDR_W"); end
   if (SYNC_STAGES < 2)     begin : g_bad_ss  $error("SYNC_STAGES must be at least 2");   end

   logic [2:0]       pins_q;
   logic             s_cs_n, s_sclk, s_sdi, s_sclk_d;
   logic             sel, rise, fall;
   logic [CNT_W-1:0] bit_cnt;
   logic             cmd_valid, cmd_rd, rd_req;

   srp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_q)
   );
   assign {s_cs_n, s_sclk, s_sdi} = pins_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_sclk_d <= 1'b0;
      else        s_sclk_d <= s_sclk;
   end

   assign sel  = ~s_cs_n;
   assign rise = sel &  s_sclk & ~s_sclk_d;
   assign fall = sel & ~s_sclk &  s_sclk_d;

   srp_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .sdi(s_sdi),
      .bit_cnt(bit_cnt), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
      .cmd_addr(reg_addr), .wr_en(reg_we), .wr_data(reg_wdata), .rd_req(rd_req)
   );

   srp_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .fall(fall),
      .spol(spol), .bit_cnt(bit_cnt), .load(rd_req), .rdata(reg_rdata),
      .sdo(sdo), .sdo_oe(sdo_oe)
   );

   assign reg_re = rd_req;
endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk #(
   parameter int CNT_W      = 5,
   parameter int FRAME_BITS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             cmd_valid,
   input logic             cmd_rd,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             sdo_oe,
   input logic             reg_we,
   input logic             reg_re
);
   // R2: a write commit is a single-cycle strobe
   a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R9: a commit needs the frame to have been selected on the cycle before
   a_r9_we_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(sel));

   // R9: a deselected port releases the output on the next cycle
   a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !sdo_oe);

   // R6: no drive once a write command has been decoded
   a_r6_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cmd_valid && !cmd_rd) |-> !sdo_oe);

   // R4: output is only ever enabled within a read frame
   a_r4_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> cmd_rd);

   // R10: one read strobe per read command
   a_r10_re_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   a_r10_re_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> (cmd_valid && cmd_rd));

   // R11: bit count saturates at the frame length
   a_r11_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_BITS));
endmodule

bind srp_port srp_port_chk #(.CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
   .bit_cnt(bit_cnt), .sdo_oe(sdo_oe), .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/tb_srp_port.sv
module tb_srp_port;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, spol = 1'b0;
   logic       sdo, sdo_oe, reg_we, reg_re;
   logic [3:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] regs [16];

   int n_chk = 0, n_err = 0;
   int we_n = 0, re_n = 0, oe_n = 0;
   logic [3:0] we_a = '0, re_a = '0;
   logic [7:0] we_d = '0;

   logic [7:0] rdv;
   logic       oe_ok, oe_last, oe_after;

   always #2.5 clk = ~clk;

   srp_port dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .spol(spol),
      .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
   );

   // register file model and strobe monitor
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
      end else if (reg_we) begin
         regs[reg_addr] <= reg_wdata;
      end
      if (reg_we) begin we_n <= we_n + 1; we_a <= reg_addr; we_d <= reg_wdata; end
      if (reg_re) begin re_n <= re_n + 1; re_a <= reg_addr; end
      if (sdo_oe) oe_n <= oe_n + 1;
   end
   assign reg_rdata = regs[reg_addr];

   function automatic logic [7:0] pat(int a);
      return 8'(a * 37 + 5);
   endfunction

   task automatic wclk(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one frame; nbits < 16 aborts by deasserting select
   task automatic frame(logic rd, logic [3:0] a, logic [7:0] d, logic sp,
                        logic idle, int extra, int nbits);
      logic [15:0] word;
      word = {d, 3'b000, a, rd};
      spol = sp; sclk = idle; cs_n = 1'b1;
      wclk(H);
      cs_n = 1'b0;
      wclk(H);
      rdv = 8'h00; oe_ok = 1'b1; oe_last = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0; sdi = word[i];
         wclk(H);
         if (i >= 8 && !sp) begin rdv[i-8] = sdo; oe_ok &= sdo_oe; end
         sclk = 1'b1;
         wclk(4);
         sdi = ~word[i];   // falling-edge value is junk (R3)
         wclk(H - 4);
         if (i >= 8 && sp) begin rdv[i-8] = sdo; oe_ok &= sdo_oe; end
         if (i == 15) oe_last = sdo_oe;
      end
      for (int e = 0; e < extra; e++) begin
         sclk = 1'b0; sdi = 1'b1; wclk(H);
         sclk = 1'b1; wclk(H);
      end
      if (nbits == 16) begin
         sclk = 1'b0; wclk(H);
         oe_after = sdo_oe;
         sclk = idle; wclk(H);
      end
      cs_n = 1'b1;
      wclk(H);
      oe_after = (nbits == 16) ? oe_after : sdo_oe;
   endtask

   initial begin
      int we0, re0, oe0;
      rst_n = 1'b0;
      wclk(4);
      chk("R1", sdo_oe, 0, "oe in reset");
      chk("R1", reg_we, 0, "we in reset");
      rst_n = 1'b1;
      wclk(2);
      chk("R1", {reg_we, reg_re, sdo_oe}, 0, "strobes after reset");

      // writes to every address, both idle levels, junk on falling edges
      for (int a = 0; a < 16; a++) begin
         we0 = we_n; oe0 = oe_n;
         frame(1'b0, 4'(a), pat(a), a[1], a[0], (a == 3) ? 5 : 0, 16);
         chk("R2", we_n - we0, 1, "write strobe count");
         chk("R2", we_a, a, "write address");
         chk("R3", we_d, pat(a), "write data");
         chk("R6", oe_n - oe0, 0, "drive cycles during write");
         if (a == 3) chk("R11", we_n - we0, 1, "extra edges after frame");
      end

      // reads of every address, both polarities, both idle levels
      for (int sp = 0; sp < 2; sp++)
         for (int idle = 0; idle < 2; idle++)
            for (int a = 0; a < 16; a++) begin
               we0 = we_n; re0 = re_n;
               frame(1'b1, 4'(a), 8'h00, sp[0], idle[0], (a == 7) ? 3 : 0, 16);
               chk(sp ? "R5" : "R4", rdv, pat(a), "read data");
               chk(sp ? "R5" : "R4", oe_ok, 1, "enable over data bits");
               chk("R7", oe_last, sp, "enable just after D7 rising edge");
               chk("R7", oe_after, 0, "float after D7");
               chk("R10", re_n - re0, 1, "read strobe count");
               chk("R10", re_a, a, "read strobe address");
               chk("R2", we_n - we0, 0, "no write on read");
               if (idle == 1 && a == 0) chk("R8", rdv, pat(0), "idle high read");
               if (a == 7) chk("R11", oe_after, 0, "extra edges after read");
            end

      // aborted write leaves the register untouched
      we0 = we_n;
      frame(1'b0, 4'd5, 8'hA5, 1'b0, 1'b0, 0, 12);
      chk("R9", we_n - we0, 0, "aborted write strobe");
      frame(1'b1, 4'd5, 8'h00, 1'b0, 1'b0, 0, 16);
      chk("R9", rdv, pat(5), "register after aborted write");

      // aborted read releases the line, next frame is clean
      frame(1'b1, 4'd9, 8'h00, 1'b1, 1'b1, 0, 11);
      chk("R9", oe_after, 0, "float after aborted read");
      frame(1'b1, 4'd9, 8'h00, 1'b1, 1'b0, 0, 16);
      chk("R9", rdv, pat(9), "read after abort");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule